// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides a fast oscillator-side clock by a programmable total ratio of N×M+S. A dual-modulus prescaler divides the clock by either N or N+1. The block drives the prescaler's modulus-select line and counts the prescaler's output ticks with two counters. An 11-bit main count M sets how many prescaler ticks make one full output cycle. A 7-bit swallow count S sets how many of those ticks, at the start of each cycle, are taken at the larger ratio N+1. One full output cycle is therefore S·(N+1) + (M−S)·N clocks, which is N×M+S. At the end of each cycle the block emits a single one-clock pulse for the phase comparator.

A behavioural model of the prescaler is part of the design, so the whole chain can be checked in digital simulation. Its base modulus N is either 64 or 128. The settings M, S and the modulus choice arrive as parallel inputs and are copied into working registers only at a cycle boundary. If a setting is loaded with M not greater than S, the block raises an error flag and emits no output pulses until a valid setting has been loaded at a later boundary.

Top module: `swallow_divider`

## Requirements
- R1: With a valid setting (M > S), consecutive output pulses are exactly N×M+S clock cycles apart.
- R2: `cfgSelLow` = 1 selects base modulus N = 64 (prescaler ratios 64/65). `cfgSelLow` = 0 selects N = 128 (ratios 128/129).
- R3: In each output cycle, `modCtrl` is 1 for the first S prescaler periods, each N+1 clocks long, and 0 for the rest of the cycle. It is therefore high for S·(N+1) clocks per cycle, and never high when S = 0.
- R4: `pscTick` pulses exactly M times per output cycle, and the last of these pulses coincides with the cycle boundary.
- R5: `divPulse` is high for exactly one clock per output cycle.
- R6: While `rstN` is low, `divPulse` and `pscTick` are 0, `modCtrl` equals (S ≠ 0) and `cfgError` equals (M ≤ S) for the inputs present. The first `divPulse` rises N×M+S clocks after the last reset edge.
- R7: A change to `cfgMain`, `cfgSwallow` or `cfgSelLow` in the middle of a cycle does not alter that cycle. The new setting governs the cycles after the next boundary.
- R8: When the setting loaded at a boundary has M ≤ S (including M = 0), `cfgError` is 1 from that boundary on and no `divPulse` occurs.
- R9: After a valid setting is applied during the error state, `cfgError` clears at the next boundary. The first `divPulse` then follows N×M+S clocks after that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-side clock being divided |
| rstN | input | 1 | Synchronous active-low reset; loads the setting inputs |
| cfgMain | input | 11 | Main count M, unsigned, bit 0 is LSB |
| cfgSwallow | input | 7 | Swallow count S, unsigned, bit 0 is LSB |
| cfgSelLow | input | 1 | 1: N = 64, 0: N = 128 |
| divPulse | output | 1 | One-clock pulse at the end of each full division cycle |
| modCtrl | output | 1 | Modulus select to the prescaler, 1 selects N+1 |
| pscTick | output | 1 | Prescaler output tick, high in the last clock of each prescaler period |
| cfgError | output | 1 | Active setting has M ≤ S |

## Verification
The cycle boundary is the clock edge at which the prescaler tick ending the M-th period is taken. The working setting loads on that same edge, so `divPulse` and a new `cfgError` value are seen in the clock right after it. The bench samples on falling edges and measures each cycle from one pulse to the next. Over that window it counts clocks, `modCtrl`-high samples and `pscTick` samples. This gives exactly N×M+S, S·(N+1) and M samples, with no offset to account for. A setting is written in the clock in which a pulse is seen, so the next interval still belongs to the old setting. The bench skips that interval, except where R7 measures it on purpose.

// File: rtl/swallow_divider_pkg.sv
package swallow_divider_pkg;

  // Strobes from control to datapath, one clock each.
  typedef struct packed {
    logic count;       // prescaler tick inside a cycle
    logic reload;      // prescaler tick closing a cycle
    logic swallowEnd;  // prescaler tick closing the last N+1 period
  } ctlStrobes_t;

  // Status from datapath to control.
  typedef struct packed {
    logic mainLast;    // next tick closes the cycle
    logic swLast;      // next tick closes the swallow phase
    logic swPending;   // swallow phase still running
    logic cfgBad;      // active setting has M <= S
    logic nextSwalNz;  // pending setting has S != 0
  } dpStatus_t;

endpackage

// File: rtl/swallow_divider_psc.sv
module swallow_divider_psc #(
  parameter int LOW_MOD  = 64,
  parameter int HIGH_MOD = 128
) (
  input  logic clk,
  input  logic rstN,
  input  logic selLow,
  input  logic modCtrl,
  output logic pscTick
);
  localparam int PSC_W = $clog2(HIGH_MOD + 2);
  localparam logic [PSC_W-1:0] LOW_TERM  = PSC_W'(LOW_MOD - 1);
  localparam logic [PSC_W-1:0] HIGH_TERM = PSC_W'(HIGH_MOD - 1);

  logic [PSC_W-1:0] pscCnt;
  logic [PSC_W-1:0] term;

  // Ratio N or N+1; the inputs change only on a tick, when the count restarts.
  always_comb begin
    term = (selLow ? LOW_TERM : HIGH_TERM) + PSC_W'(modCtrl);
  end

  assign pscTick = (pscCnt == term);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pscCnt <= '0;
    end else if (pscTick) begin
      pscCnt <= '0;
    end else begin
      pscCnt <= pscCnt + PSC_W'(1);
    end
  end

  // R2: the count never passes the terminal value of the selected ratio
  a_r2_psc_bound: assert property (@(posedge clk) disable iff (!rstN)
    pscCnt <= term);

endmodule

// File: rtl/swallow_divider_dp.sv
module swallow_divider_dp
  import swallow_divider_pkg::*;
#(
  parameter int MAIN_W = 11,
  parameter int SWAL_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MAIN_W-1:0] cfgMain,
  input  logic [SWAL_W-1:0] cfgSwallow,
  input  logic              cfgSelLow,
  input  logic              pscTick,
  input  ctlStrobes_t       stb,
  output dpStatus_t         status,
  output logic              activeSelLow
);
  localparam int PAD_W = MAIN_W - SWAL_W;

  logic [MAIN_W-1:0] activeMain;
  logic [SWAL_W-1:0] activeSwal;
  logic [MAIN_W-1:0] mainCnt;
  logic [SWAL_W-1:0] swCnt;
  logic [MAIN_W:0]   mainNext;
  logic [SWAL_W:0]   swNext;

  always_comb begin
    mainNext          = {1'b0, mainCnt} + (MAIN_W+1)'(1);
    swNext            = {1'b0, swCnt} + (SWAL_W+1)'(1);
    status.mainLast   = mainNext >= {1'b0, activeMain};
    status.swLast     = swNext == {1'b0, activeSwal};
    status.swPending  = swCnt < activeSwal;
    status.cfgBad     = activeMain <= {{PAD_W{1'b0}}, activeSwal};
    status.nextSwalNz = cfgSwallow != '0;
  end

  // Setting is copied only at a cycle boundary (and during reset).
  always_ff @(posedge clk) begin
    if (!rstN || stb.reload) begin
      activeMain   <= cfgMain;
      activeSwal   <= cfgSwallow;
      activeSelLow <= cfgSelLow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.reload) begin
      mainCnt <= '0;
      swCnt   <= '0;
    end else if (stb.count) begin
      mainCnt <= mainCnt + MAIN_W'(1);
      if (status.swPending) begin
        swCnt <= swCnt + SWAL_W'(1);
      end
    end
  end

  // R1: a boundary leaves both counters at their start value
  a_r1_reload_clears: assert property (@(posedge clk) disable iff (!rstN)
    stb.reload |=> (mainCnt == '0 && swCnt == '0));

  // R4: with a valid setting the main count stays below M
  a_r4_main_in_range: assert property (@(posedge clk) disable iff (!rstN)
    !status.cfgBad |-> (mainCnt < activeMain));

  // R4: counting happens only on prescaler ticks
  a_r4_count_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !$past(pscTick) |-> $stable(mainCnt));

endmodule

// File: rtl/swallow_divider_ctrl.sv
module swallow_divider_ctrl
  import swallow_divider_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pscTick,
  input  dpStatus_t   status,
  output ctlStrobes_t stb,
  output logic        modCtrl,
  output logic        divPulse
);

  always_comb begin
    stb.count      = pscTick && !status.mainLast;
    stb.reload     = pscTick && status.mainLast;
    stb.swallowEnd = pscTick && status.swLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modCtrl  <= status.nextSwalNz;
      divPulse <= 1'b0;
    end else begin
      divPulse <= stb.reload && !status.cfgBad;
      if (stb.reload) begin
        modCtrl <= status.nextSwalNz;
      end else if (stb.swallowEnd) begin
        modCtrl <= 1'b0;
      end
    end
  end

  // R5: the output pulse lasts one clock
  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |=> !divPulse);

  // R3: the modulus select moves only on a prescaler tick
  a_r3_mod_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modCtrl) |-> $past(pscTick));

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swallow_divider_pkg::*;
#(
  parameter int MAIN_W   = 11,
  parameter int SWAL_W   = 7,
  parameter int LOW_MOD  = 64,
  parameter int HIGH_MOD = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MAIN_W-1:0] cfgMain,
  input  logic [SWAL_W-1:0] cfgSwallow,
  input  logic              cfgSelLow,
  output logic              divPulse,
  output logic              modCtrl,
  output logic              pscTick,
  output logic              cfgError
);
  ctlStrobes_t stb;
  dpStatus_t   status;
  logic        activeSelLow;

  swallow_divider_psc #(.LOW_MOD(LOW_MOD), .HIGH_MOD(HIGH_MOD)) uPsc (
    .clk(clk), .rstN(rstN), .selLow(activeSelLow),
    .modCtrl(modCtrl), .pscTick(pscTick)
  );

  swallow_divider_dp #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) uDp (
    .clk(clk), .rstN(rstN), .cfgMain(cfgMain), .cfgSwallow(cfgSwallow),
    .cfgSelLow(cfgSelLow), .pscTick(pscTick), .stb(stb),
    .status(status), .activeSelLow(activeSelLow)
  );

  swallow_divider_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .pscTick(pscTick), .status(status),
    .stb(stb), .modCtrl(modCtrl), .divPulse(divPulse)
  );

  assign cfgError = status.cfgBad;

  // R3: N+1 is selected exactly while swallow periods remain
  a_r3_mod_tracks_swallow: assert property (@(posedge clk) disable iff (!rstN)
    modCtrl == status.swPending);

  // R8: a pulse only closes a cycle whose setting was valid
  a_r8_no_pulse_on_bad: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |-> !$past(cfgError));

endmodule

// File: tb/sim_swallow_divider.sv
module sim_swallow_divider;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] cfgMain = '0;
  logic [6:0]  cfgSwallow = '0;
  logic        cfgSelLow = 1'b1;
  logic        divPulse, modCtrl, pscTick, cfgError;

  int pc = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  swallow_divider u0 (
    .clk(clk), .rstN(rstN), .cfgMain(cfgMain), .cfgSwallow(cfgSwallow),
    .cfgSelLow(cfgSelLow), .divPulse(divPulse), .modCtrl(modCtrl),
    .pscTick(pscTick), .cfgError(cfgError)
  );

  always #5 clk = ~clk;
  always @(posedge clk) pc++;

  function automatic int baseN(bit sel);
    return sel ? 64 : 128;
  endfunction

  function automatic int expPeriod(int m, int s, bit sel);
    return baseN(sel) * m + s;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply(int m, int s, bit sel);
    cfgMain = 11'(m);
    cfgSwallow = 7'(s);
    cfgSelLow = sel;
  endtask

  task automatic waitPulse(string req, output int at);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!divPulse && n < 30000);
    at = pc;
    if (!divPulse) check(1'b0, req, "pulse timeout", 0, 1);
  endtask

  // Precondition: at the falling edge where a pulse is seen.
  task automatic measureOne(int m, int s, bit sel, string req);
    int t = 0;
    int hi = 0;
    int ps = 0;
    do begin
      if (modCtrl) hi++;
      if (pscTick) ps++;
      t++;
      @(negedge clk);
    end while (!divPulse && t < 30000);
    check(t == expPeriod(m, s, sel), req, "period clocks", t, expPeriod(m, s, sel));
    check(hi == s * (baseN(sel) + 1), "R3", "modCtrl high clocks", hi, s * (baseN(sel) + 1));
    check(ps == m, "R4", "prescaler ticks per cycle", ps, m);
    check(t > 1, "R5", "pulse width over one clock", t, 2);
  endtask

  initial begin
    int at0, at1, cnt, relPc;
    void'($urandom(32'd1357));

    // R6: reset state
    apply(4, 2, 1'b1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(divPulse == 0, "R6", "divPulse in reset", divPulse, 0);
    check(pscTick == 0, "R6", "pscTick in reset", pscTick, 0);
    check(modCtrl == 1, "R6", "modCtrl in reset", modCtrl, 1);
    check(cfgError == 0, "R6", "cfgError in reset", cfgError, 0);
    rstN = 1'b1;
    relPc = pc;
    waitPulse("R6", at0);
    check(at0 - relPc == 258, "R6", "first pulse delay", at0 - relPc, 258);

    // R1: main function, N = 64
    measureOne(4, 2, 1'b1, "R1");
    measureOne(4, 2, 1'b1, "R1");

    // R2: N = 128
    apply(3, 1, 1'b0);
    waitPulse("R2", at0);
    measureOne(3, 1, 1'b0, "R2");
    measureOne(3, 1, 1'b0, "R2");

    // R3: no swallow
    apply(5, 0, 1'b1);
    waitPulse("R3", at0);
    measureOne(5, 0, 1'b1, "R3");

    // R1: wider counts
    apply(100, 99, 1'b1);
    waitPulse("R1", at0);
    measureOne(100, 99, 1'b1, "R1");

    // R7: mid-cycle change leaves the running cycle intact
    apply(6, 3, 1'b1);
    waitPulse("R7", at0);
    waitPulse("R7", at0);
    repeat (100) @(negedge clk);
    apply(2, 1, 1'b0);
    waitPulse("R7", at1);
    check(at1 - at0 == 387, "R7", "cycle in progress period", at1 - at0, 387);
    measureOne(2, 1, 1'b0, "R7");

    // R8: M <= S
    apply(3, 5, 1'b1);
    waitPulse("R8", at0);
    check(cfgError == 1, "R8", "cfgError after bad load", cfgError, 1);
    cnt = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (divPulse) cnt++;
    end
    check(cnt == 0, "R8", "pulses with M<S", cnt, 0);
    apply(0, 0, 1'b1);
    cnt = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (divPulse) cnt++;
    end
    check(cnt == 0, "R8", "pulses with M=0", cnt, 0);
    check(cfgError == 1, "R8", "cfgError with M=0", cfgError, 1);

    // R9: recovery
    apply(4, 0, 1'b1);
    cnt = 0;
    while (cfgError && cnt < 500) begin
      @(negedge clk);
      cnt++;
    end
    check(cfgError == 0, "R9", "cfgError cleared", cfgError, 0);
    at0 = pc;
    waitPulse("R9", at1);
    check(at1 - at0 == 256, "R9", "first pulse after recovery", at1 - at0, 256);
    measureOne(4, 0, 1'b1, "R9");

    // R1: random settings
    for (int k = 0; k < 12; k++) begin
      int m, s;
      bit sel;
      m = 2 + int'($urandom_range(10));
      s = int'($urandom_range(m - 1));
      sel = 1'($urandom_range(1));
      apply(m, s, sel);
      waitPulse("R1", at0);
      measureOne(m, s, sel, "R1");
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", pc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule